// File: doc/BRIEF.md
# Timed-Arm Configuration Read Window

This controller sits next to a processor's program-memory read port. Normally every read returns the program-memory byte that the memory presents for the requested address. Software can arm the block by writing a command. After that, a read issued within a short window of cycles is redirected. It then returns a byte from an identification and calibration row, or from nonvolatile fuse storage, in place of program memory.

The block has two arm modes. The signature mode selects the read-only row of identification and calibration bytes. The fuse mode selects the extended and high fuse bytes. The arm bits clear themselves when a redirected read completes. They also clear when the window runs out unused. The arm state can be read back on two status outputs. The signature row and the fuse storage reach the block as parallel byte inputs.

Every read, redirected or not, is answered with a registered byte one cycle after its request.

Top module: `cfgrd_window`

## Requirements
- R1: With no arm active, a read request returns the `pmem_data` value presented in the request cycle on `rd_data`, with `rd_valid` high, in the following cycle.
- R2: In signature mode, a read of address a (0 to 5) returns `sig_row[8a+7:8a]`. The row layout is: 0 = identification byte 1, 1 = oscillator calibration, 2 = identification byte 2, 3 = temperature offset, 4 = identification byte 3, 5 = temperature gain.
- R3: In fuse mode, address 0x0002 returns the extended fuse byte and address 0x0003 returns the high fuse byte. Each output bit is the inverse of the matching `*_prog` input bit: a programmed bit (1) reads as 0 and an unprogrammed bit reads as 1.
- R4: In an active window, a read of a reserved address returns 0xFF. Reserved addresses are signature addresses above 5 and fuse addresses other than 2 and 3.
- R5: Any read issued inside an active window clears both arm status outputs in the next cycle. This includes reads of reserved addresses.
- R6: A read is redirected only if it is requested in one of the first 3 cycles after the arm write. If no read arrives in that time, the arm bits clear, and a read in the 4th cycle returns program memory.
- R7: An arm write with both mode bits set enables no redirection. Both status bits show 1 for one cycle and then clear, and a read during that cycle returns program memory.
- R8: An arm write while a window is open restarts the full 3-cycle window from that write.
- R9: An arm write with both mode bits at 0 disarms at once.
- R10: A synchronous active-high `rst` clears the arm bits, the window counter, `rd_valid` and `rd_data`.
- R11: When an arm write and a read request fall in the same cycle, the read is served with the arm state from before the write, and the newly written arm state is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| arm_we | input | 1 | Arm command write strobe |
| arm_sig | input | 1 | Arm command bit: signature mode |
| arm_fuse | input | 1 | Arm command bit: fuse mode |
| rd_req | input | 1 | Read request strobe |
| rd_addr | input | 16 | Read byte address |
| pmem_data | input | 8 | Program-memory byte for `rd_addr` |
| sig_row | input | 48 | Signature row, byte a at bits 8a+7:8a |
| fuse_high_prog | input | 8 | High fuse bits, 1 = programmed |
| fuse_ext_prog | input | 8 | Extended fuse bits, 1 = programmed |
| rd_data | output | 8 | Registered read data |
| rd_valid | output | 1 | Read data valid, one cycle after `rd_req` |
| arm_sig_st | output | 1 | Status: signature arm bit |
| arm_fuse_st | output | 1 | Status: fuse arm bit |

## Verification
A window counter that is wrong, or that fails to clear, shows up at the ports as a read that is redirected when it should not be, or the reverse. The first affected read exposes it on `rd_data`, one cycle after its request. The status outputs expose a stuck arm bit one cycle after the read or expiry that should have cleared it. A wrong address decode appears on `rd_data` at the first access to the affected byte. The bench therefore sweeps every row address, both fuse addresses, reserved addresses and each window delay, then checks data and status together.

// File: rtl/cfgrd_pkg.sv
package cfgrd_pkg;

    localparam int BYTE_W = 8;
    localparam logic [BYTE_W-1:0] RESERVED_BYTE = 8'hFF;

    typedef enum logic [1:0] {
        WIN_NONE = 2'd0,
        WIN_SIG  = 2'd1,
        WIN_FUSE = 2'd2
    } win_mode_e;

endpackage

// File: rtl/cfgrd_arm_ctrl.sv
module cfgrd_arm_ctrl
    import cfgrd_pkg::*;
#(
    parameter int WIN_CYC = 3
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      arm_we_i,
    input  logic      arm_sig_i,
    input  logic      arm_fuse_i,
    input  logic      rd_req_i,
    output win_mode_e mode_o,
    output logic      arm_sig_o,
    output logic      arm_fuse_o
);

    localparam int CNT_W = $clog2(WIN_CYC + 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(WIN_CYC);
    localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

    typedef struct packed {
        logic             sig;
        logic             fuse;
        logic [CNT_W-1:0] cnt;
    } arm_s;

    arm_s st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (arm_we_i) begin
            // a new command always wins; an ambiguous one opens no window
            st_d.sig  = arm_sig_i;
            st_d.fuse = arm_fuse_i;
            st_d.cnt  = (arm_sig_i ^ arm_fuse_i) ? CNT_FULL : '0;
        end else if (st_q.sig | st_q.fuse) begin
            if ((st_q.sig & st_q.fuse) || rd_req_i || (st_q.cnt <= CNT_ONE)) begin
                st_d = '0;
            end else begin
                st_d.cnt = st_q.cnt - CNT_ONE;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        if (st_q.sig && !st_q.fuse) begin
            mode_o = WIN_SIG;
        end else if (st_q.fuse && !st_q.sig) begin
            mode_o = WIN_FUSE;
        end else begin
            mode_o = WIN_NONE;
        end
    end

    assign arm_sig_o  = st_q.sig;
    assign arm_fuse_o = st_q.fuse;

    a_r5_read_clears: assert property (@(posedge clk) disable iff (rst)
        (mode_o != WIN_NONE && rd_req_i && !arm_we_i) |=> !(arm_sig_o || arm_fuse_o));

    a_r6_expire: assert property (@(posedge clk) disable iff (rst)
        (mode_o != WIN_NONE && st_q.cnt == CNT_ONE && !rd_req_i && !arm_we_i)
        |=> (mode_o == WIN_NONE));

    a_r6_live_window: assert property (@(posedge clk) disable iff (rst)
        (mode_o != WIN_NONE) |-> (st_q.cnt != '0));

    a_r7_both_drop: assert property (@(posedge clk) disable iff (rst)
        (arm_sig_o && arm_fuse_o && !arm_we_i) |=> !(arm_sig_o || arm_fuse_o));

    a_r8_restart: assert property (@(posedge clk) disable iff (rst)
        (arm_we_i && (arm_sig_i ^ arm_fuse_i)) |=> (mode_o != WIN_NONE));

    a_r9_disarm: assert property (@(posedge clk) disable iff (rst)
        (arm_we_i && !arm_sig_i && !arm_fuse_i) |=> (mode_o == WIN_NONE && !arm_sig_o && !arm_fuse_o));

    a_r10_reset: assert property (@(posedge clk)
        rst |=> (st_q == '0));

endmodule

// File: rtl/cfgrd_byte_sel.sv
module cfgrd_byte_sel
    import cfgrd_pkg::*;
#(
    parameter int ADDR_W         = 16,
    parameter int SIG_BYTES      = 6,
    parameter int FUSE_EXT_ADDR  = 2,
    parameter int FUSE_HIGH_ADDR = 3
) (
    input  win_mode_e                  mode_i,
    input  logic [ADDR_W-1:0]          addr_i,
    input  logic [BYTE_W-1:0]          pmem_i,
    input  logic [SIG_BYTES*BYTE_W-1:0] sig_row_i,
    input  logic [BYTE_W-1:0]          fuse_high_prog_i,
    input  logic [BYTE_W-1:0]          fuse_ext_prog_i,
    output logic [BYTE_W-1:0]          byte_o
);

    localparam logic [ADDR_W-1:0] EXT_A  = ADDR_W'(FUSE_EXT_ADDR);
    localparam logic [ADDR_W-1:0] HIGH_A = ADDR_W'(FUSE_HIGH_ADDR);

    logic [SIG_BYTES-1:0] sig_hit;
    logic [BYTE_W-1:0]    sig_byte [SIG_BYTES];
    logic [BYTE_W-1:0]    sig_val;
    logic [BYTE_W-1:0]    fuse_val;

    for (genvar g = 0; g < SIG_BYTES; g++) begin : g_sig
        assign sig_byte[g] = sig_row_i[g*BYTE_W +: BYTE_W];
        assign sig_hit[g]  = (addr_i == ADDR_W'(g));
    end

    always_comb begin
        sig_val = RESERVED_BYTE;
        for (int i = 0; i < SIG_BYTES; i++) begin
            if (sig_hit[i]) begin
                sig_val = sig_byte[i];
            end
        end
    end

    // stored bits mark programmed cells with 1; the read view is active-low
    always_comb begin
        if (addr_i == EXT_A) begin
            fuse_val = ~fuse_ext_prog_i;
        end else if (addr_i == HIGH_A) begin
            fuse_val = ~fuse_high_prog_i;
        end else begin
            fuse_val = RESERVED_BYTE;
        end
    end

    always_comb begin
        unique case (mode_i)
            WIN_SIG:  byte_o = sig_val;
            WIN_FUSE: byte_o = fuse_val;
            default:  byte_o = pmem_i;
        endcase
    end

endmodule

// File: rtl/cfgrd_window.sv
module cfgrd_window
    import cfgrd_pkg::*;
#(
    parameter int ADDR_W         = 16,
    parameter int WIN_CYC        = 3,
    parameter int SIG_BYTES      = 6,
    parameter int FUSE_EXT_ADDR  = 2,
    parameter int FUSE_HIGH_ADDR = 3
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        arm_we,
    input  logic                        arm_sig,
    input  logic                        arm_fuse,
    input  logic                        rd_req,
    input  logic [ADDR_W-1:0]           rd_addr,
    input  logic [BYTE_W-1:0]           pmem_data,
    input  logic [SIG_BYTES*BYTE_W-1:0] sig_row,
    input  logic [BYTE_W-1:0]           fuse_high_prog,
    input  logic [BYTE_W-1:0]           fuse_ext_prog,
    output logic [BYTE_W-1:0]           rd_data,
    output logic                        rd_valid,
    output logic                        arm_sig_st,
    output logic                        arm_fuse_st
);

    typedef struct packed {
        logic              vld;
        logic [BYTE_W-1:0] data;
    } rsp_s;

    win_mode_e         mode;
    logic [BYTE_W-1:0] sel_byte;
    rsp_s              rsp_d, rsp_q;

    cfgrd_arm_ctrl #(
        .WIN_CYC (WIN_CYC)
    ) arm_i (
        .clk        (clk),
        .rst        (rst),
        .arm_we_i   (arm_we),
        .arm_sig_i  (arm_sig),
        .arm_fuse_i (arm_fuse),
        .rd_req_i   (rd_req),
        .mode_o     (mode),
        .arm_sig_o  (arm_sig_st),
        .arm_fuse_o (arm_fuse_st)
    );

    cfgrd_byte_sel #(
        .ADDR_W         (ADDR_W),
        .SIG_BYTES      (SIG_BYTES),
        .FUSE_EXT_ADDR  (FUSE_EXT_ADDR),
        .FUSE_HIGH_ADDR (FUSE_HIGH_ADDR)
    ) sel_i (
        .mode_i           (mode),
        .addr_i           (rd_addr),
        .pmem_i           (pmem_data),
        .sig_row_i        (sig_row),
        .fuse_high_prog_i (fuse_high_prog),
        .fuse_ext_prog_i  (fuse_ext_prog),
        .byte_o           (sel_byte)
    );

    always_comb begin
        rsp_d     = rsp_q;
        rsp_d.vld = rd_req;
        if (rd_req) begin
            rsp_d.data = sel_byte;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_q <= '0;
        end else begin
            rsp_q <= rsp_d;
        end
    end

    assign rd_valid = rsp_q.vld;
    assign rd_data  = rsp_q.data;

    a_r1_normal_read: assert property (@(posedge clk) disable iff (rst)
        (rd_req && mode == WIN_NONE) |=> (rd_valid && rd_data == $past(pmem_data)));

    a_r4_sig_reserved: assert property (@(posedge clk) disable iff (rst)
        (rd_req && mode == WIN_SIG && rd_addr >= ADDR_W'(SIG_BYTES)) |=> (rd_data == RESERVED_BYTE));

    a_r3_fuse_ext: assert property (@(posedge clk) disable iff (rst)
        (rd_req && mode == WIN_FUSE && rd_addr == ADDR_W'(FUSE_EXT_ADDR))
        |=> (rd_data == ~$past(fuse_ext_prog)));

    a_r10_reset_out: assert property (@(posedge clk)
        rst |=> (!rd_valid && rd_data == '0));

endmodule

// File: tb/cfgrd_window_tb_top.sv
`timescale 1ns/1ps
module cfgrd_window_tb_top;

    localparam int NVEC = 16;
    // fields: [31:24] mode (0 none, 1 signature, 2 fuse), [23:16] idle cycles, [15:0] address
    localparam logic [31:0] VEC [NVEC] = '{
        {8'd0, 8'd0, 16'h0010},
        {8'd1, 8'd0, 16'h0000},
        {8'd1, 8'd0, 16'h0001},
        {8'd1, 8'd1, 16'h0002},
        {8'd1, 8'd2, 16'h0003},
        {8'd1, 8'd0, 16'h0004},
        {8'd1, 8'd1, 16'h0005},
        {8'd1, 8'd0, 16'h0006},
        {8'd1, 8'd0, 16'h1234},
        {8'd2, 8'd0, 16'h0002},
        {8'd2, 8'd2, 16'h0003},
        {8'd2, 8'd0, 16'h0000},
        {8'd2, 8'd1, 16'h0004},
        {8'd1, 8'd3, 16'h0001},
        {8'd2, 8'd3, 16'h0002},
        {8'd0, 8'd1, 16'h00C3}
    };

    localparam logic [47:0] SIG_VAL  = {8'hC7, 8'h33, 8'h5A, 8'h84, 8'h96, 8'h1E};
    localparam logic [7:0]  HIGH_PRG = 8'h26;
    localparam logic [7:0]  EXT_PRG  = 8'h03;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        arm_we = 1'b0, arm_sig = 1'b0, arm_fuse = 1'b0;
    logic        rd_req = 1'b0;
    logic [15:0] rd_addr = '0;
    logic [7:0]  pmem_data;
    logic [7:0]  rd_data;
    logic        rd_valid, arm_sig_st, arm_fuse_st;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    assign pmem_data = rd_addr[7:0] ^ 8'hA5;

    cfgrd_window dut_i (
        .clk            (clk),
        .rst            (rst),
        .arm_we         (arm_we),
        .arm_sig        (arm_sig),
        .arm_fuse       (arm_fuse),
        .rd_req         (rd_req),
        .rd_addr        (rd_addr),
        .pmem_data      (pmem_data),
        .sig_row        (SIG_VAL),
        .fuse_high_prog (HIGH_PRG),
        .fuse_ext_prog  (EXT_PRG),
        .rd_data        (rd_data),
        .rd_valid       (rd_valid),
        .arm_sig_st     (arm_sig_st),
        .arm_fuse_st    (arm_fuse_st)
    );

    function automatic logic [7:0] model(input int mode, input int idle, input logic [15:0] a);
        if (mode == 0 || idle >= 3) return a[7:0] ^ 8'hA5;
        if (mode == 1) return (a < 16'd6) ? SIG_VAL[a[2:0]*8 +: 8] : 8'hFF;
        if (a == 16'd2) return ~EXT_PRG;
        if (a == 16'd3) return ~HIGH_PRG;
        return 8'hFF;
    endfunction

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic arm(input logic s, input logic f);
        @(negedge clk);
        arm_we = 1'b1; arm_sig = s; arm_fuse = f;
    endtask

    task automatic idle_cyc();
        @(negedge clk);
        arm_we = 1'b0; rd_req = 1'b0;
    endtask

    task automatic rd(input logic [15:0] a);
        @(negedge clk);
        arm_we = 1'b0; rd_req = 1'b1; rd_addr = a;
        @(negedge clk);
        rd_req = 1'b0;
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=%h expected=%h", 8'h00, 8'h01);
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R10 reset state
        chk("R10 rd_valid", {7'd0, rd_valid}, 8'h00);
        chk("R10 rd_data", rd_data, 8'h00);
        chk("R10 arm bits", {6'd0, arm_sig_st, arm_fuse_st}, 8'h00);

        for (int v = 0; v < NVEC; v++) begin
            int md = int'(VEC[v][31:24]);
            int dl = int'(VEC[v][23:16]);
            logic [15:0] a = VEC[v][15:0];
            if (md != 0) arm(md == 1, md == 2);
            for (int k = 0; k < dl; k++) idle_cyc();
            rd(a);
            // R1 R2 R3 R4 R6 depending on vector
            chk($sformatf("R2/R3/R4/R6/R1 vec %0d data", v), rd_data, model(md, dl, a));
            chk($sformatf("R1 vec %0d valid", v), {7'd0, rd_valid}, 8'h01);
            chk($sformatf("R5 vec %0d arm cleared", v), {6'd0, arm_sig_st, arm_fuse_st}, 8'h00);
            idle_cyc();
        end

        // R6 expiry without read: status drops after 3 cycles
        arm(1'b1, 1'b0);
        idle_cyc();
        chk("R6 armed in window", {6'd0, arm_sig_st, arm_fuse_st}, 8'h02);
        idle_cyc(); idle_cyc();
        chk("R6 still armed cycle 3", {6'd0, arm_sig_st, arm_fuse_st}, 8'h02);
        idle_cyc();
        chk("R6 expired", {6'd0, arm_sig_st, arm_fuse_st}, 8'h00);

        // R7 both bits
        arm(1'b1, 1'b1);
        @(negedge clk);
        chk("R7 both shown", {6'd0, arm_sig_st, arm_fuse_st}, 8'h03);
        arm_we = 1'b0; rd_req = 1'b1; rd_addr = 16'h0002;
        @(negedge clk);
        rd_req = 1'b0;
        chk("R7 read normal", rd_data, 8'h02 ^ 8'hA5);
        chk("R7 bits cleared", {6'd0, arm_sig_st, arm_fuse_st}, 8'h00);
        idle_cyc();

        // R8 re-arm restarts window
        arm(1'b0, 1'b1);
        idle_cyc(); idle_cyc();
        arm(1'b0, 1'b1);
        idle_cyc(); idle_cyc();
        rd(16'h0003);
        chk("R8 restarted window", rd_data, ~HIGH_PRG);
        idle_cyc();

        // R9 disarm
        arm(1'b1, 1'b0);
        arm(1'b0, 1'b0);
        rd(16'h0001);
        chk("R9 disarmed read", rd_data, 8'h01 ^ 8'hA5);
        chk("R9 status", {6'd0, arm_sig_st, arm_fuse_st}, 8'h00);
        idle_cyc();

        // R11 arm and read in the same cycle
        arm(1'b1, 1'b0);
        @(negedge clk);
        arm_we = 1'b1; arm_sig = 1'b0; arm_fuse = 1'b1;
        rd_req = 1'b1; rd_addr = 16'h0003;
        @(negedge clk);
        arm_we = 1'b0; rd_req = 1'b0;
        chk("R11 old state served", rd_data, 8'h5A);
        chk("R11 new arm kept", {6'd0, arm_sig_st, arm_fuse_st}, 8'h01);
        rd(16'h0002);
        chk("R11 new window used", rd_data, ~EXT_PRG);
        idle_cyc();

        // R10 reset in an open window
        arm(1'b1, 1'b0);
        @(negedge clk);
        arm_we = 1'b0; rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk("R10 mid-window arm", {6'd0, arm_sig_st, arm_fuse_st}, 8'h00);
        rd(16'h0000);
        chk("R10 post-reset read", rd_data, 8'h00 ^ 8'hA5);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule